// File: doc/BRIEF.md
# Compare Flags and Branch Condition Unit

This block keeps a four-bit status register that a compare operation alone may change. When the compare strobe is high, the block subtracts the second operand from the first. On the next clock edge it stores four flags from that subtraction: negative, zero, carry and overflow. All other cycles leave the flags untouched, so an instruction stream may place any number of non-compare operations between a compare and the branch that consumes it.

A branch condition selector is evaluated combinationally against the stored flags and yields a single taken signal. The supported tests are equal, not-equal, signed less-than and signed greater-than. There is also an always-taken code. The remaining selector codes are never taken.

The block has one piece of state, the flag register, with two transitions. The UPDATE transition fires on a clock edge with the strobe high. The HOLD transition fires on every other edge. Synchronous reset forces the CLEAR value of all-zero flags.

Top module: `cmp_branch_unit`

## Requirements
- R1: While `rst` is high at a clock edge, the flags become 0000 on that edge. The `flags` bit order is {N, Z, C, V}, with N at bit 3 and V at bit 0.
- R2: A clock edge with `cmp_valid` high loads the flags derived from `opd_a - opd_b`, sampled on that same edge, so they are visible in the following cycle.
- R3: A clock edge with `cmp_valid` low (and `rst` low) leaves `flags` unchanged, whatever the operands and selector do.
- R4: N is the most significant bit of the WIDTH-bit difference. Z is 1 exactly when all WIDTH bits of the difference are zero.
- R5: C is 1 when the unsigned subtraction needs no borrow, that is, when `opd_a >= opd_b` unsigned.
- R6: V is 1 when the subtraction overflows as a two's-complement operation, meaning the true signed difference falls outside the WIDTH-bit signed range.
- R7: Selector code 0 (equal) makes `taken` equal Z. Code 1 (not-equal) makes `taken` equal the inverse of Z.
- R8: Selector code 2 (signed less-than) makes `taken` high exactly when N differs from V.
- R9: Selector code 3 (signed greater-than) makes `taken` high exactly when Z is clear and N equals V.
- R10: Selector code 4 (always) makes `taken` 1 regardless of the flags. Codes 5, 6 and 7 make `taken` 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| cmp_valid | input | 1 | Compare strobe; the operands are compared this cycle |
| opd_a | input | WIDTH | First compare operand (minuend) |
| opd_b | input | WIDTH | Second compare operand (subtrahend) |
| cond_sel | input | 3 | Branch condition selector code |
| flags | output | 4 | Stored status {N, Z, C, V} |
| taken | output | 1 | Branch taken for the selected condition |

## Verification
The embedded assertions check, on every cycle, several rules that relate ports across one edge:
- the flags hold when no compare is strobed;
- the zero and carry flags match the equality and unsigned ordering of the previous operands;
- a compare followed by a less-than selection gives the signed ordering of those operands;
- the always code is taken;
- reset yields clear flags.

The negative and overflow flags taken one at a time, and the equal, not-equal and greater-than codes against operands at the signed extremes, are shown only by the bench. It sweeps every operand pair of a four-bit configuration and, after each pair, tests all eight selector codes against signed and unsigned orderings computed independently.

// File: rtl/cmpflag_pkg.sv
package cmpflag_pkg;

    localparam int unsigned COND_W = 3;

    typedef enum logic [COND_W-1:0] {
        COND_EQ  = 3'd0,
        COND_NE  = 3'd1,
        COND_LT  = 3'd2,
        COND_GT  = 3'd3,
        COND_AL  = 3'd4,
        COND_RS5 = 3'd5,
        COND_RS6 = 3'd6,
        COND_RS7 = 3'd7
    } cond_t;

    typedef struct packed {
        logic neg;
        logic zero;
        logic carry;
        logic ovf;
    } flags_t;

    typedef enum logic [1:0] {
        FL_CLEAR  = 2'd0,
        FL_UPDATE = 2'd1,
        FL_HOLD   = 2'd2
    } fl_step_t;

endpackage

// File: rtl/cmp_subtract.sv
module cmp_subtract
    import cmpflag_pkg::*;
#(
    parameter int unsigned WIDTH = 32
) (
    input  logic [WIDTH-1:0] opd_a,
    input  logic [WIDTH-1:0] opd_b,
    output flags_t           result
);
    localparam int unsigned MSB = WIDTH - 1;

    logic [WIDTH:0]   wide_diff;
    logic [WIDTH-1:0] diff;
    logic             borrow;

    always_comb begin
        wide_diff = {1'b0, opd_a} - {1'b0, opd_b};
        diff      = wide_diff[WIDTH-1:0];
        borrow    = wide_diff[WIDTH];

        result.neg   = diff[MSB];
        result.zero  = (diff == '0);
        result.carry = ~borrow;
        result.ovf   = (opd_a[MSB] != opd_b[MSB]) && (diff[MSB] != opd_a[MSB]);
    end

endmodule

// File: rtl/cmp_flag_reg.sv
module cmp_flag_reg
    import cmpflag_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   cmp_valid,
    input  flags_t next_flags,
    output flags_t cur_flags
);
    fl_step_t step;

    always_comb begin
        if (rst)            step = FL_CLEAR;
        else if (cmp_valid) step = FL_UPDATE;
        else                step = FL_HOLD;
    end

    always_ff @(posedge clk) begin
        unique case (step)
            FL_CLEAR:  cur_flags <= '0;
            FL_UPDATE: cur_flags <= next_flags;
            FL_HOLD:   cur_flags <= cur_flags;
            default:   cur_flags <= '0;
        endcase
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk) rst |=> cur_flags == '0);

    // R3
    flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !cmp_valid |=> $stable(cur_flags));

    // R2
    flag_load_chk: assert property (@(posedge clk) disable iff (rst)
        cmp_valid |=> cur_flags == $past(next_flags));

endmodule

// File: rtl/cmp_branch_eval.sv
module cmp_branch_eval
    import cmpflag_pkg::*;
(
    input  logic [COND_W-1:0] cond_sel,
    input  flags_t            cur_flags,
    output logic              taken
);
    cond_t cond;
    logic  n_ne_v;

    always_comb begin
        cond   = cond_t'(cond_sel);
        n_ne_v = cur_flags.neg ^ cur_flags.ovf;
        unique case (cond)
            COND_EQ: taken = cur_flags.zero;
            COND_NE: taken = ~cur_flags.zero;
            COND_LT: taken = n_ne_v;
            COND_GT: taken = ~cur_flags.zero & ~n_ne_v;
            COND_AL: taken = 1'b1;
            default: taken = 1'b0;
        endcase
    end

    // R10
    always_comb begin
        if (cond_sel > 3'd4) begin
            reserved_never_chk: assert (taken == 1'b0);
        end
    end

endmodule

// File: rtl/cmp_branch_unit.sv
module cmp_branch_unit
    import cmpflag_pkg::*;
#(
    parameter int unsigned WIDTH = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmp_valid,
    input  logic [WIDTH-1:0]  opd_a,
    input  logic [WIDTH-1:0]  opd_b,
    input  logic [COND_W-1:0] cond_sel,
    output logic [3:0]        flags,
    output logic              taken
);
    flags_t sub_flags;
    flags_t held_flags;

    cmp_subtract #(.WIDTH(WIDTH)) u_sub (
        .opd_a  (opd_a),
        .opd_b  (opd_b),
        .result (sub_flags)
    );

    cmp_flag_reg u_freg (
        .clk        (clk),
        .rst        (rst),
        .cmp_valid  (cmp_valid),
        .next_flags (sub_flags),
        .cur_flags  (held_flags)
    );

    cmp_branch_eval u_br (
        .cond_sel  (cond_sel),
        .cur_flags (held_flags),
        .taken     (taken)
    );

    assign flags = held_flags;

    // R4
    zero_equal_chk: assert property (@(posedge clk) disable iff (rst)
        cmp_valid |=> flags[2] == (opd_a_q == opd_b_q));

    // R5
    carry_noborrow_chk: assert property (@(posedge clk) disable iff (rst)
        cmp_valid |=> flags[1] == (opd_a_q >= opd_b_q));

    // R8
    lt_signed_chk: assert property (@(posedge clk) disable iff (rst)
        (cmp_valid ##1 (cond_sel == 3'd2)) |-> taken == ($signed(opd_a_q) < $signed(opd_b_q)));

    // R10
    always_taken_chk: assert property (@(posedge clk) disable iff (rst)
        (cond_sel == 3'd4) |-> taken);

    logic [WIDTH-1:0] opd_a_q;
    logic [WIDTH-1:0] opd_b_q;

    always_ff @(posedge clk) begin
        opd_a_q <= opd_a;
        opd_b_q <= opd_b;
    end

endmodule

// File: tb/cmp_branch_unit_tb.sv
module cmp_branch_unit_tb;
    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         cmp_valid = 1'b0;
    logic [W-1:0] opd_a = '0;
    logic [W-1:0] opd_b = '0;
    logic [2:0]   cond_sel = 3'd0;
    logic [3:0]   flags;
    logic         taken;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    cmp_branch_unit #(.WIDTH(W)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .cmp_valid (cmp_valid),
        .opd_a     (opd_a),
        .opd_b     (opd_b),
        .cond_sel  (cond_sel),
        .flags     (flags),
        .taken     (taken)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int sval(input int u);
        return (u >= 8) ? u - 16 : u;
    endfunction

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        #2_000_000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int ua, ub, sa, sb, sd, en, ez, ec, ev, ef, exp_t;
        logic [3:0] saved;
        @(negedge clk);
        @(negedge clk);
        chk("R1 reset flags", int'(flags), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R3 idle after reset", int'(flags), 0);
        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
                opd_a = a[W-1:0];
                opd_b = b[W-1:0];
                cmp_valid = 1'b1;
                @(negedge clk);
                cmp_valid = 1'b0;
                ua = a; ub = b;
                sa = sval(a); sb = sval(b); sd = sa - sb;
                en = (((ua - ub) & 15) >= 8) ? 1 : 0;
                ez = (ua == ub) ? 1 : 0;
                ec = (ua >= ub) ? 1 : 0;
                ev = (sd < -8 || sd > 7) ? 1 : 0;
                ef = en * 8 + ez * 4 + ec * 2 + ev;
                chk("R2 R4 R5 R6 flags after compare", int'(flags), ef);
                for (int c = 0; c < 8; c++) begin
                    cond_sel = c[2:0];
                    #1;
                    case (c)
                        0: exp_t = (sa == sb) ? 1 : 0;
                        1: exp_t = (sa != sb) ? 1 : 0;
                        2: exp_t = (sa < sb) ? 1 : 0;
                        3: exp_t = (sa > sb) ? 1 : 0;
                        4: exp_t = 1;
                        default: exp_t = 0;
                    endcase
                    if (c < 2)       chk("R7 eq/ne taken", int'(taken), exp_t);
                    else if (c == 2) chk("R8 lt taken", int'(taken), exp_t);
                    else if (c == 3) chk("R9 gt taken", int'(taken), exp_t);
                    else             chk("R10 always/reserved taken", int'(taken), exp_t);
                end
                cond_sel = 3'd0;
                if (b == 5) begin
                    saved = flags;
                    opd_a = ~opd_a;
                    opd_b = opd_b + 4'd3;
                    cond_sel = 3'd2;
                    @(negedge clk);
                    chk("R3 hold without strobe", int'(flags), int'(saved));
                    cond_sel = 3'd0;
                end
            end
        end
        opd_a = 4'd3; opd_b = 4'd9; cmp_valid = 1'b1;
        @(negedge clk);
        cmp_valid = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        chk("R1 reset clears nonzero flags", int'(flags), 0);
        rst = 1'b0;
        finish_run();
    end

endmodule